// File: doc/BRIEF.md
# Next-PC and Exception Sequencer

This block holds the fetch address and the following fetch address of a 32-bit processor whose architecture has one branch delay slot. Every clock it moves forward by one instruction. The execute stage feeds it the decoded control of the instruction that sits at the current address. That control says whether the instruction is a conditional branch, whether its condition is met, whether it is a branch-likely form, whether it is a direct jump or a register jump, and whether it requests an exception. The execute stage also supplies the immediate, the jump target field and the register operand. From these the block works out the address that follows the delay slot.

A branch-likely instruction whose condition fails annuls its delay-slot instruction. An exception request also annuls the instruction already fetched. While an instruction is annulled, all of its control inputs are ignored. An exception saves a return address, sends fetch to a fixed vector and leaves user mode. The return address is the faulting address plus 4, with bit 1 set when the faulting instruction sat in a delay slot. A link output gives the return address for link-form branches and jumps, which is the address after the delay slot.

Top module: `pc_seq_unit`

## Requirements
- R1: While rst_ni is low, pc_o is 0, pc_next_o is 4, annul_o is 0, epc_o is 0 and user_mode_o is 0.
- R2: At each rising edge pc_o takes the previous pc_next_o. With no redirect, pc_next_o takes its previous value plus 4.
- R3: When br_en_i and br_cond_i are both high, pc_next_o becomes the previous pc_next_o plus the sign-extended imm_i shifted left by 2. When br_en_i is high and br_cond_i is low, the step is sequential.
- R4: When jump_i is high, pc_next_o becomes the top 4 bits of the previous pc_next_o (the delay-slot address), then target_i, then two zero bits.
- R5: When jump_reg_i is high, pc_next_o becomes reg_val_i with bits 1:0 cleared. The priority is register jump first, then direct jump, then conditional branch.
- R6: When br_en_i, br_likely_i and a low br_cond_i arrive together, annul_o is high for the next cycle and the step is sequential. A branch-likely whose condition holds is taken as in R3 and annuls nothing.
- R7: In a cycle with annul_o high, every control input is ignored: pc_next_o steps by 4, no exception is taken, user mode is not set, and annul_o falls.
- R8: When exc_req_i is high in a cycle that is not annulled, epc_o becomes pc_o plus 4. Bit 1 of epc_o is set if pc_next_o was not pc_o plus 4. In the same step pc_next_o becomes 0x3C, annul_o rises and user_mode_o clears.
- R9: An exception request takes priority over any branch, jump, register jump, branch-likely annul or user-mode set presented in the same cycle.
- R10: link_addr_o always equals pc_next_o plus 4.
- R11: user_mode_set_i in a cycle that is neither annulled nor excepting sets user_mode_o at the next edge. The flag then holds until an exception occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| br_en_i | input | 1 | Instruction at pc_o is a conditional branch |
| br_cond_i | input | 1 | Branch condition result |
| br_likely_i | input | 1 | Branch is the likely form |
| jump_i | input | 1 | Direct jump |
| jump_reg_i | input | 1 | Jump to register value |
| exc_req_i | input | 1 | Exception request |
| user_mode_set_i | input | 1 | Enter user mode |
| imm_i | input | 16 | Branch immediate, in words |
| target_i | input | 26 | Jump target field, in words |
| reg_val_i | input | 32 | Register operand for a register jump |
| pc_o | output | 32 | Address of the executing instruction |
| pc_next_o | output | 32 | Address of the following fetch |
| annul_o | output | 1 | Instruction at pc_o is annulled |
| link_addr_o | output | 32 | Link value, the address after the delay slot |
| epc_o | output | 32 | Saved exception return address |
| user_mode_o | output | 1 | User mode flag |

## Verification
The controls presented in one cycle show up on pc_o, pc_next_o, annul_o, epc_o and user_mode_o at the very next rising edge. All of these outputs are registered. link_addr_o is combinational and follows pc_next_o in the same cycle. The driver applies inputs just after a rising edge and updates an independent model. After the next rising edge it queues the expected values. The monitor checks them at the falling edge that follows, so every check falls exactly one register stage after its stimulus. The stimulus includes annulled cycles carrying jump and exception controls, and exceptions raised both in and out of a delay slot.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;
  typedef enum logic [2:0] {
    SEL_SEQ,
    SEL_BR,
    SEL_JMP,
    SEL_JREG,
    SEL_VEC
  } pc_sel_e;
endpackage

// File: rtl/pc_sel_dec.sv
module pc_sel_dec
  import pc_seq_pkg::*;
(
  input  logic    annul_q_i,
  input  logic    br_en_i,
  input  logic    br_cond_i,
  input  logic    br_likely_i,
  input  logic    jump_i,
  input  logic    jump_reg_i,
  input  logic    exc_req_i,
  input  logic    user_mode_set_i,
  output pc_sel_e sel_o,
  output logic    annul_d_o,
  output logic    exc_take_o,
  output logic    um_set_o
);
  logic live;
  assign live = ~annul_q_i;

  always_comb begin
    sel_o      = SEL_SEQ;
    annul_d_o  = 1'b0;
    exc_take_o = 1'b0;
    um_set_o   = 1'b0;
    if (live) begin
      if (exc_req_i) begin
        sel_o      = SEL_VEC;
        annul_d_o  = 1'b1;
        exc_take_o = 1'b1;
      end else begin
        um_set_o = user_mode_set_i;
        if (jump_reg_i)                 sel_o = SEL_JREG;
        else if (jump_i)                sel_o = SEL_JMP;
        else if (br_en_i && br_cond_i)  sel_o = SEL_BR;
        // likely form with failed condition kills its delay slot
        annul_d_o = br_en_i && br_likely_i && !br_cond_i && !jump_i && !jump_reg_i;
      end
    end
  end
endmodule

// File: rtl/pc_target_gen.sv
module pc_target_gen
  import pc_seq_pkg::*;
#(
  parameter int unsigned         AW    = 32,
  parameter int unsigned         IMM_W = 16,
  parameter int unsigned         TGT_W = 26,
  parameter logic [AW-1:0]       VEC   = 32'h0000_003C
) (
  input  pc_sel_e           sel_i,
  input  logic [AW-1:0]     pc_next_q_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [TGT_W-1:0]  target_i,
  input  logic [AW-1:0]     reg_val_i,
  output logic [AW-1:0]     pc_next_d_o,
  output logic [AW-1:0]     link_o
);
  localparam int unsigned   EXT_W = AW - IMM_W - 2;
  localparam int unsigned   HI_W  = AW - TGT_W - 2;
  localparam logic [AW-1:0] STEP  = AW'(4);
  localparam logic [AW-1:0] LOW2  = AW'(3);

  logic [AW-1:0] seq_addr, br_addr, jmp_addr, jreg_addr, br_off;

  assign seq_addr  = pc_next_q_i + STEP;
  // (npc + 4) + (imm << 2) - 4
  assign br_off    = {{EXT_W{imm_i[IMM_W-1]}}, imm_i, 2'b00};
  assign br_addr   = pc_next_q_i + br_off;
  assign jmp_addr  = {pc_next_q_i[AW-1 -: HI_W], target_i, 2'b00};
  assign jreg_addr = reg_val_i & ~LOW2;
  assign link_o    = seq_addr;

  always_comb begin
    unique case (sel_i)
      SEL_BR:   pc_next_d_o = br_addr;
      SEL_JMP:  pc_next_d_o = jmp_addr;
      SEL_JREG: pc_next_d_o = jreg_addr;
      SEL_VEC:  pc_next_d_o = VEC;
      default:  pc_next_d_o = seq_addr;
    endcase
  end
endmodule

// File: rtl/epc_capture.sv
module epc_capture #(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          exc_take_i,
  input  logic          um_set_i,
  input  logic [AW-1:0] pc_q_i,
  input  logic [AW-1:0] pc_next_q_i,
  output logic [AW-1:0] epc_o,
  output logic          user_mode_o
);
  localparam logic [AW-1:0] STEP = AW'(4);

  logic [AW-1:0] ret_addr;
  logic          in_slot;

  assign ret_addr = pc_q_i + STEP;
  assign in_slot  = (pc_next_q_i != ret_addr);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      epc_o       <= '0;
      user_mode_o <= 1'b0;
    end else begin
      if (exc_take_i) begin
        epc_o       <= {ret_addr[AW-1:2], in_slot, ret_addr[0]};
        user_mode_o <= 1'b0;
      end else if (um_set_i) begin
        user_mode_o <= 1'b1;
      end
    end
  end

  p_user_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_take_i |=> !user_mode_o);
  p_epc_slot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_take_i && (pc_next_q_i != pc_q_i + STEP)) |=> epc_o[1]);
  p_epc_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exc_take_i |=> $stable(epc_o));
endmodule

// File: rtl/pc_seq_unit.sv
module pc_seq_unit
  import pc_seq_pkg::*;
#(
  parameter int unsigned   AW     = 32,
  parameter int unsigned   IMM_W  = 16,
  parameter int unsigned   TGT_W  = 26,
  parameter logic [AW-1:0] RST_PC = 32'h0000_0000,
  parameter logic [AW-1:0] VEC    = 32'h0000_003C
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             br_en_i,
  input  logic             br_cond_i,
  input  logic             br_likely_i,
  input  logic             jump_i,
  input  logic             jump_reg_i,
  input  logic             exc_req_i,
  input  logic             user_mode_set_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [TGT_W-1:0] target_i,
  input  logic [AW-1:0]    reg_val_i,
  output logic [AW-1:0]    pc_o,
  output logic [AW-1:0]    pc_next_o,
  output logic             annul_o,
  output logic [AW-1:0]    link_addr_o,
  output logic [AW-1:0]    epc_o,
  output logic             user_mode_o
);
  localparam logic [AW-1:0] STEP = AW'(4);

  logic [AW-1:0] pc_q, pc_next_q, pc_next_d;
  logic          annul_q, annul_d, exc_take, um_set;
  pc_sel_e       sel;

  pc_sel_dec i_dec (
    .annul_q_i       (annul_q),
    .br_en_i         (br_en_i),
    .br_cond_i       (br_cond_i),
    .br_likely_i     (br_likely_i),
    .jump_i          (jump_i),
    .jump_reg_i      (jump_reg_i),
    .exc_req_i       (exc_req_i),
    .user_mode_set_i (user_mode_set_i),
    .sel_o           (sel),
    .annul_d_o       (annul_d),
    .exc_take_o      (exc_take),
    .um_set_o        (um_set)
  );

  pc_target_gen #(.AW(AW), .IMM_W(IMM_W), .TGT_W(TGT_W), .VEC(VEC)) i_tgt (
    .sel_i       (sel),
    .pc_next_q_i (pc_next_q),
    .imm_i       (imm_i),
    .target_i    (target_i),
    .reg_val_i   (reg_val_i),
    .pc_next_d_o (pc_next_d),
    .link_o      (link_addr_o)
  );

  epc_capture #(.AW(AW)) i_epc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .exc_take_i  (exc_take),
    .um_set_i    (um_set),
    .pc_q_i      (pc_q),
    .pc_next_q_i (pc_next_q),
    .epc_o       (epc_o),
    .user_mode_o (user_mode_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q      <= RST_PC;
      pc_next_q <= RST_PC + STEP;
      annul_q   <= 1'b0;
    end else begin
      pc_q      <= pc_next_q;
      pc_next_q <= pc_next_d;
      annul_q   <= annul_d;
    end
  end

  assign pc_o      = pc_q;
  assign pc_next_o = pc_next_q;
  assign annul_o   = annul_q;

  p_seq_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> pc_q == $past(pc_next_q));
  p_align_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |-> pc_next_q[1:0] == 2'b00);
  p_likely_annul_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!annul_q && !exc_req_i && !jump_i && !jump_reg_i && br_en_i && br_likely_i && !br_cond_i)
      |=> annul_q && pc_next_q == $past(pc_next_q) + STEP);
  p_ignore_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    annul_q |=> !annul_q && pc_next_q == $past(pc_next_q) + STEP);
  p_vector_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!annul_q && exc_req_i) |=> annul_q && pc_next_q == VEC);
  p_prio_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!annul_q && exc_req_i && (jump_i || jump_reg_i || br_en_i)) |=> pc_next_q == VEC);
  p_link_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> link_addr_o == $past(pc_next_d) + STEP);
endmodule

// File: tb/test_pc_seq_unit.sv
`timescale 1ns/1ps
module test_pc_seq_unit;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        br_en, br_cond, br_likely, jump, jump_reg, exc_req, um_set;
  logic [15:0] imm;
  logic [25:0] tgt;
  logic [31:0] reg_val;
  logic [31:0] pc, pc_next, link, epc;
  logic        annul, um;

  int checks = 0;
  int errors = 0;

  typedef struct packed {
    logic [31:0] pc;
    logic [31:0] npc;
    logic [31:0] epc;
    logic        annul;
    logic        um;
  } exp_t;
  exp_t  exp_q[$];
  string tag_q[$];

  logic [31:0] m_pc, m_npc, m_epc;
  logic        m_annul, m_um;

  always #2 clk = ~clk;

  pc_seq_unit i_pc_seq_unit (
    .clk_i(clk), .rst_ni(rst_ni), .br_en_i(br_en), .br_cond_i(br_cond),
    .br_likely_i(br_likely), .jump_i(jump), .jump_reg_i(jump_reg),
    .exc_req_i(exc_req), .user_mode_set_i(um_set), .imm_i(imm),
    .target_i(tgt), .reg_val_i(reg_val), .pc_o(pc), .pc_next_o(pc_next),
    .annul_o(annul), .link_addr_o(link), .epc_o(epc), .user_mode_o(um)
  );

  task automatic check32(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s actual=%08h expected=%08h", tag, what, act, expv);
    end
  endtask

  // monitor: compare queued expectations one edge after their stimulus
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t  e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check32(t, "pc", pc, e.pc);
      check32(t, "pc_next", pc_next, e.npc);
      check32(t, "annul", {31'd0, annul}, {31'd0, e.annul});
      check32(t, "epc", epc, e.epc);
      check32(t, "user_mode", {31'd0, um}, {31'd0, e.um});
      check32("R10", "link", link, e.npc + 32'd4);
    end
  end

  task automatic step(input logic b_en, input logic b_c, input logic b_l,
                      input logic j, input logic jr, input logic ex,
                      input logic us, input logic [15:0] im,
                      input logic [25:0] tg, input logic [31:0] rv,
                      input string tag);
    logic [31:0] nn;
    exp_t e;
    br_en = b_en; br_cond = b_c; br_likely = b_l; jump = j; jump_reg = jr;
    exc_req = ex; um_set = us; imm = im; tgt = tg; reg_val = rv;
    if (m_annul) begin
      nn = m_npc + 32'd4;
      m_annul = 1'b0;
    end else if (ex) begin
      m_epc = (m_pc + 32'd4) | ((m_npc != m_pc + 32'd4) ? 32'd2 : 32'd0);
      nn = 32'h3C;
      m_annul = 1'b1;
      m_um = 1'b0;
    end else begin
      if (jr)              nn = rv & 32'hFFFF_FFFC;
      else if (j)          nn = {m_npc[31:28], tg, 2'b00};
      else if (b_en && b_c) nn = m_npc + {{14{im[15]}}, im, 2'b00};
      else                 nn = m_npc + 32'd4;
      m_annul = b_en && b_l && !b_c && !j && !jr;
      if (us) m_um = 1'b1;
    end
    m_pc  = m_npc;
    m_npc = nn;
    e.pc = m_pc; e.npc = m_npc; e.epc = m_epc; e.annul = m_annul; e.um = m_um;
    @(posedge clk);
    #1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 16'h0, 26'h0, 32'h0, tag);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    br_en = 0; br_cond = 0; br_likely = 0; jump = 0; jump_reg = 0;
    exc_req = 0; um_set = 0; imm = '0; tgt = '0; reg_val = '0;
    m_pc = 32'h0; m_npc = 32'h4; m_epc = 32'h0; m_annul = 1'b0; m_um = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check32("R1", "pc", pc, 32'h0);
    check32("R1", "pc_next", pc_next, 32'h4);
    check32("R1", "annul", {31'd0, annul}, 32'd0);
    check32("R1", "epc", epc, 32'h0);
    check32("R1", "user_mode", {31'd0, um}, 32'd0);
    @(posedge clk);
    #1 rst_ni = 1'b1;

    idle("R2");
    idle("R2");
    step(1, 1, 0, 0, 0, 0, 0, 16'd3, 26'h0, 32'h0, "R3");     // forward taken
    idle("R3");
    step(1, 0, 0, 0, 0, 0, 0, 16'd20, 26'h0, 32'h0, "R3");    // not taken
    step(1, 1, 0, 0, 0, 0, 0, 16'hFFFE, 26'h0, 32'h0, "R3");  // backward
    idle("R3");
    step(0, 0, 0, 0, 1, 0, 0, 16'h0, 26'h0, 32'h8000_0103, "R5");
    idle("R5");
    step(0, 0, 0, 1, 0, 0, 0, 16'h0, 26'h012_3456, 32'h0, "R4");
    idle("R4");
    step(1, 1, 0, 1, 1, 0, 0, 16'd9, 26'h0_0040, 32'h0000_0200, "R5");
    idle("R5");
    step(1, 0, 1, 0, 0, 0, 0, 16'd7, 26'h0, 32'h0, "R6");     // likely false
    step(0, 0, 0, 1, 1, 1, 1, 16'h0, 26'h3FF_FFFF, 32'h0000_1000, "R7");
    idle("R7");
    step(1, 1, 1, 0, 0, 0, 0, 16'd5, 26'h0, 32'h0, "R6");     // likely true
    idle("R6");
    step(0, 0, 0, 0, 0, 0, 1, 16'h0, 26'h0, 32'h0, "R11");
    idle("R11");
    step(0, 0, 0, 0, 0, 1, 0, 16'h0, 26'h0, 32'h0, "R8");     // no slot
    idle("R8");
    idle("R8");
    step(1, 1, 0, 0, 0, 0, 1, 16'd4, 26'h0, 32'h0, "R11");
    step(0, 0, 0, 0, 0, 1, 0, 16'h0, 26'h0, 32'h0, "R8");     // in slot
    idle("R8");
    step(0, 0, 0, 1, 0, 1, 1, 16'h0, 26'h100, 32'h0, "R9");
    idle("R9");
    step(1, 0, 1, 0, 0, 1, 0, 16'd2, 26'h0, 32'h0, "R9");
    idle("R9");
    idle("R2");
    @(posedge clk);
    @(negedge clk);
    #1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule